// File: doc/BRIEF.md
# SDRAM Write Burst Termination Sequencer

This block sits on the controller side of an SDRAM interface. It opens a write burst, streams the data beats and ends the burst early when it is asked to. The burst can be cut short in two ways. A read can take over the bus, in which case the block turns the DQ bus around in time for the read data. A precharge can close one bank or all banks, in which case the block waits out the write-recovery gap and masks the unused beats before it closes the row. After a precharge it issues the follow-up activate. Every cycle it drives a registered command (chip select, row strobe, column strobe, write enable), a bank and an address, the DQ output enable, DQM, the index of the write beat being driven, and a flag marking the cycles in which read data is to be captured.

Burst length, CAS latency, the single-write mode flag and the recovery count are sampled each time a write is accepted. The beat index tells the surrounding datapath which data word to place on DQ.

Top module: `wburst_term`

## Requirements
- R1: While reset is held and in the first cycle after it, the command is NOP (CS#=0, RAS#=1, CAS#=1, WE#=1), dq_oe and dqm are low and ready is high.
- R2: When wr_req is high in a cycle with ready high, the next cycle carries WRITE (CS#=0, RAS#=1, CAS#=0, WE#=0) with bank wr_bank and address wr_col. Beats 0 to B-1 then follow in consecutive cycles with dq_oe high and wr_beat equal to the beat number. B is 1, 2, 4 or 8 for bl_code 0, 1, 2 or 3. In the cycle after the last beat the command is NOP and ready is high.
- R3: With brsw high, the write burst is one beat whatever bl_code says. The read burst length still follows bl_code.
- R4: int_req takes effect only in a cycle that carries a write beat, and that beat becomes the last one driven. int_req at any other time, and wr_req while ready is low, change nothing.
- R5: For a read interrupt (int_kind 0), READ (CS#=0, RAS#=1, CAS#=0, WE#=1) with int_bank and int_col appears in the cycle after the last beat. dq_oe is low from that cycle onward.
- R6: rd_valid is high for RL cycles, starting CL cycles after the READ cycle. CL is cas_lat, with 0 treated as 1, and RL is the read burst length from bl_code. ready rises in the cycle after the last rd_valid.
- R7: For a precharge interrupt, PRECHARGE (CS#=0, RAS#=0, CAS#=1, WE#=0) appears m cycles after the last beat. m is twr, with 0 treated as 1. int_kind 1 closes bank int_bank and drives address bit 10 low. int_kind 2 or 3 closes all banks and drives address bit 10 high.
- R8: In a precharge interrupt with B greater than 2, dqm is high from the cycle after the last beat through the PRECHARGE cycle. With B of 1 or 2, dqm stays low.
- R9: ACTIVATE (CS#=0, RAS#=0, CAS#=1, WE#=1) with bank int_bank and address act_row (both captured with the interrupt) appears TRP_CYC cycles after PRECHARGE. ready is high in that cycle.
- R10: dq_oe is never high in a cycle in which the device drives read data, that is, from CL to CL+RL-1 cycles after a READ.
- R11: Every cycle not named above carries NOP, and dqm is low whenever dq_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Start a write burst |
| wr_col | input | COL_W | Write column |
| wr_bank | input | BANK_W | Write bank |
| int_req | input | 1 | End the current write burst |
| int_kind | input | 2 | 0 read, 1 precharge one bank, 2/3 precharge all |
| int_col | input | COL_W | Read column for a read interrupt |
| int_bank | input | BANK_W | Bank for read, precharge and activate |
| act_row | input | ROW_W | Row for the follow-up activate |
| bl_code | input | 2 | Burst length code (1 shifted left by code) |
| brsw | input | 1 | Single-beat write mode |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| twr | input | TWR_W | Write recovery cycles m |
| ready | output | 1 | Idle, a write may be requested |
| cs_n | output | 1 | Chip select, low active |
| ras_n | output | 1 | Row strobe, low active |
| cas_n | output | 1 | Column strobe, low active |
| we_n | output | 1 | Write enable, low active |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus |
| dq_oe | output | 1 | Controller drives DQ |
| dqm | output | 1 | Data mask |
| wr_beat | output | 3 | Index of the beat on DQ |
| rd_valid | output | 1 | Capture read data this cycle |

## Verification
An interrupt can land on the final beat of a burst, in the same cycle in which the burst would have ended on its own. The bench sweeps the interrupt over every beat position, including the last, for every burst length, latency and recovery count. It predicts the whole cycle trace arithmetically and compares every cycle. A second collision occurs when the recovery count is 1: the precharge then leaves in the cycle right after the request, so its bank and all-banks bit must come from the live inputs rather than the captured copy. Alternate runs also raise stray write and interrupt requests while the block is busy. The bench confirms the trace is unchanged, and its device model checks that DQ is never driven while read data is due.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

    localparam int CNT_W  = 6;
    localparam int BEAT_W = 3;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_GAP,
        ST_TRP,
        ST_RD
    } state_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_WCOL,
        SRC_ICOL,
        SRC_PRE,
        SRC_ROW
    } src_e;

    typedef struct packed {
        logic [CNT_W-1:0] wlen;
        logic [CNT_W-1:0] rlen;
        logic [CNT_W-1:0] cl;
        logic [CNT_W-1:0] m;
        logic             mask;
    } cfg_t;

    typedef struct packed {
        cmd_e              cmd;
        src_e              src;
        logic              oe;
        logic              dqm;
        logic [BEAT_W-1:0] beat;
        logic              rvld;
    } step_t;

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    function automatic logic [CNT_W-1:0] len_of(input logic [1:0] code);
        logic [CNT_W-1:0] v;
        v = '0;
        v[code] = 1'b1;
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_ONE : v;
    endfunction

    function automatic logic kind_is_read(input logic [1:0] k);
        return k == 2'd0;
    endfunction

    function automatic logic kind_is_all(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/wbt_cfg.sv
module wbt_cfg
    import wbt_pkg::*;
#(
    parameter int TWR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [1:0]       bl_code,
    input  logic             brsw,
    input  logic [1:0]       cas_lat,
    input  logic [TWR_W-1:0] twr,
    output cfg_t             cfg
);

    cfg_t nxt;

    always_comb begin
        nxt.rlen = len_of(bl_code);
        nxt.wlen = brsw ? CNT_ONE : nxt.rlen;
        nxt.cl   = floor_one(CNT_W'(cas_lat));
        nxt.m    = floor_one(CNT_W'(twr));
        nxt.mask = nxt.wlen > CNT_W'(2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (load) begin
            cfg <= nxt;
        end
    end

endmodule

// File: rtl/wbt_seq.sv
module wbt_seq
    import wbt_pkg::*;
#(
    parameter int TRP_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_req,
    input  logic       int_req,
    input  logic [1:0] int_kind,
    input  cfg_t       cfg,
    output step_t      step_nxt,
    output logic       acc_wr,
    output logic       acc_int,
    output logic       ready
);

    localparam logic [CNT_W-1:0] TRP_L = CNT_W'(TRP_CYC);

    state_e           st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n, cnt_p1;

    assign cnt_p1 = cnt + CNT_ONE;
    assign ready  = (st == ST_IDLE);

    always_comb begin
        step_nxt = '{cmd: CMD_NOP, src: SRC_NONE, oe: 1'b0, dqm: 1'b0,
                     beat: '0, rvld: 1'b0};
        st_n    = st;
        cnt_n   = cnt;
        acc_wr  = 1'b0;
        acc_int = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (wr_req) begin
                    acc_wr       = 1'b1;
                    step_nxt.cmd = CMD_WR;
                    step_nxt.src = SRC_WCOL;
                    step_nxt.oe  = 1'b1;
                    st_n         = ST_WR;
                    cnt_n        = '0;
                end
            end
            ST_WR: begin
                if (int_req) begin
                    acc_int = 1'b1;
                    if (kind_is_read(int_kind)) begin
                        step_nxt.cmd = CMD_RD;
                        step_nxt.src = SRC_ICOL;
                        st_n         = ST_RD;
                        cnt_n        = '0;
                    end else if (cfg.m == CNT_ONE) begin
                        step_nxt.cmd = CMD_PRE;
                        step_nxt.src = SRC_PRE;
                        step_nxt.dqm = cfg.mask;
                        st_n         = ST_TRP;
                        cnt_n        = '0;
                    end else begin
                        step_nxt.dqm = cfg.mask;
                        st_n         = ST_GAP;
                        cnt_n        = CNT_ONE;
                    end
                end else if (cnt_p1 == cfg.wlen) begin
                    st_n = ST_IDLE;
                end else begin
                    step_nxt.oe   = 1'b1;
                    step_nxt.beat = cnt_p1[BEAT_W-1:0];
                    cnt_n         = cnt_p1;
                end
            end
            ST_GAP: begin
                step_nxt.dqm = cfg.mask;
                if (cnt_p1 == cfg.m) begin
                    step_nxt.cmd = CMD_PRE;
                    step_nxt.src = SRC_PRE;
                    st_n         = ST_TRP;
                    cnt_n        = '0;
                end else begin
                    cnt_n = cnt_p1;
                end
            end
            ST_TRP: begin
                if (cnt_p1 == TRP_L) begin
                    step_nxt.cmd = CMD_ACT;
                    step_nxt.src = SRC_ROW;
                    st_n         = ST_IDLE;
                end else begin
                    cnt_n = cnt_p1;
                end
            end
            ST_RD: begin
                if (cnt_p1 == cfg.cl + cfg.rlen) begin
                    st_n = ST_IDLE;
                end else begin
                    step_nxt.rvld = (cnt_p1 >= cfg.cl);
                    cnt_n         = cnt_p1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

endmodule

// File: rtl/wbt_drive.sv
module wbt_drive
    import wbt_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int ROW_W  = 11,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 11,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             step_nxt,
    input  logic              acc_int,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  int_col,
    input  logic [BANK_W-1:0] int_bank,
    input  logic [1:0]        int_kind,
    input  logic [ROW_W-1:0]  act_row,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              dq_oe,
    output logic              dqm,
    output logic [BEAT_W-1:0] beat,
    output logic              rd_valid
);

    logic [BANK_W-1:0] l_bank;
    logic              l_all;
    logic [ROW_W-1:0]  l_row;
    logic [ADDR_W-1:0] a_n;
    logic [BANK_W-1:0] b_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            l_bank <= '0;
            l_all  <= 1'b0;
            l_row  <= '0;
        end else if (acc_int) begin
            l_bank <= int_bank;
            l_all  <= kind_is_all(int_kind);
            l_row  <= act_row;
        end
    end

    always_comb begin
        a_n = '0;
        b_n = '0;
        unique case (step_nxt.src)
            SRC_WCOL: begin
                a_n = ADDR_W'(wr_col);
                b_n = wr_bank;
            end
            SRC_ICOL: begin
                a_n = ADDR_W'(int_col);
                b_n = int_bank;
            end
            SRC_PRE: begin
                b_n         = acc_int ? int_bank : l_bank;
                a_n[AP_BIT] = acc_int ? kind_is_all(int_kind) : l_all;
            end
            SRC_ROW: begin
                a_n = ADDR_W'(l_row);
                b_n = l_bank;
            end
            default: begin
                a_n = '0;
                b_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            ba       <= '0;
            addr     <= '0;
            dq_oe    <= 1'b0;
            dqm      <= 1'b0;
            beat     <= '0;
            rd_valid <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= step_nxt.cmd;
            ba       <= b_n;
            addr     <= a_n;
            dq_oe    <= step_nxt.oe;
            dqm      <= step_nxt.dqm;
            beat     <= step_nxt.beat;
            rd_valid <= step_nxt.rvld;
        end
    end

endmodule

// File: rtl/wburst_term.sv
module wburst_term
    import wbt_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int ROW_W   = 11,
    parameter int BANK_W  = 2,
    parameter int ADDR_W  = 11,
    parameter int AP_BIT  = 10,
    parameter int TWR_W   = 4,
    parameter int TRP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic              int_req,
    input  logic [1:0]        int_kind,
    input  logic [COL_W-1:0]  int_col,
    input  logic [BANK_W-1:0] int_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic [1:0]        bl_code,
    input  logic              brsw,
    input  logic [1:0]        cas_lat,
    input  logic [TWR_W-1:0]  twr,
    output logic              ready,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              dq_oe,
    output logic              dqm,
    output logic [2:0]        wr_beat,
    output logic              rd_valid
);

    cfg_t  cfg;
    step_t step_nxt;
    logic  acc_wr, acc_int;

    wbt_cfg #(.TWR_W(TWR_W)) cfg_i (
        .clk(clk), .rst(rst), .load(acc_wr),
        .bl_code(bl_code), .brsw(brsw), .cas_lat(cas_lat), .twr(twr),
        .cfg(cfg)
    );

    wbt_seq #(.TRP_CYC(TRP_CYC)) seq_i (
        .clk(clk), .rst(rst), .wr_req(wr_req), .int_req(int_req),
        .int_kind(int_kind), .cfg(cfg), .step_nxt(step_nxt),
        .acc_wr(acc_wr), .acc_int(acc_int), .ready(ready)
    );

    wbt_drive #(
        .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W),
        .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
    ) drive_i (
        .clk(clk), .rst(rst), .step_nxt(step_nxt), .acc_int(acc_int),
        .wr_col(wr_col), .wr_bank(wr_bank), .int_col(int_col),
        .int_bank(int_bank), .int_kind(int_kind), .act_row(act_row),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .dq_oe(dq_oe), .dqm(dqm),
        .beat(wr_beat), .rd_valid(rd_valid)
    );

endmodule

// File: rtl/wburst_term_chk.sv
module wburst_term_chk
    import wbt_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic wr_req,
    input logic ready,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dq_oe,
    input logic dqm,
    input logic rd_valid
);

    logic [3:0] c;
    assign c = {cs_n, ras_n, cas_n, we_n};

    // R5
    rd_turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_RD) |-> !dq_oe);

    // R7
    pre_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_PRE) |-> !dq_oe);

    // R11
    drive_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !dqm);

    // R10
    capture_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !dq_oe);

    // R2
    write_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_WR) |-> $past(ready && wr_req));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!dq_oe && !dqm && !rd_valid));

    // R9
    act_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_ACT) |-> ready);

endmodule

bind wburst_term wburst_term_chk chk_i (
    .clk(clk), .rst(rst), .wr_req(wr_req), .ready(ready),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dq_oe(dq_oe), .dqm(dqm), .rd_valid(rd_valid)
);

// File: tb/wburst_term_tb_top.sv
module wburst_term_tb_top;

    localparam int COL_W = 8, ROW_W = 11, BANK_W = 2, ADDR_W = 11;
    localparam int TWR_W = 4, TRP = 2;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, wr_req, int_req, brsw, ready, cs_n, ras_n, cas_n, we_n;
    logic dq_oe, dqm, rd_valid;
    logic [COL_W-1:0] wr_col, int_col;
    logic [BANK_W-1:0] wr_bank, int_bank, ba;
    logic [ROW_W-1:0] act_row;
    logic [1:0] int_kind, bl_code, cas_lat;
    logic [TWR_W-1:0] twr;
    logic [ADDR_W-1:0] addr;
    logic [2:0] wr_beat;

    wburst_term #(.TRP_CYC(TRP)) dut_i (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_col(wr_col),
        .wr_bank(wr_bank), .int_req(int_req), .int_kind(int_kind),
        .int_col(int_col), .int_bank(int_bank), .act_row(act_row),
        .bl_code(bl_code), .brsw(brsw), .cas_lat(cas_lat), .twr(twr),
        .ready(ready), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .dq_oe(dq_oe), .dqm(dqm),
        .wr_beat(wr_beat), .rd_valid(rd_valid)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, run_no = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string cmd_tag(input logic [3:0] c);
        case (c)
            C_WR:    return "R2 command";
            C_RD:    return "R5 command";
            C_PRE:   return "R7 command";
            C_ACT:   return "R9 command";
            default: return "R11 command";
        endcase
    endfunction

    // kind: 0 none, 1 read, 2 precharge one bank, 3 precharge all
    task automatic run(input int bl, input int bs, input int cl, input int m,
                       input int kind, input int k);
        int B, RBL, CL, M, endi, last, dev_lo, dev_hi;
        bit noise;
        logic [3:0] oc, ec;
        B   = bs ? 1 : (1 << bl);
        RBL = 1 << bl;
        CL  = (cl == 0) ? 1 : cl;
        M   = (m == 0) ? 1 : m;
        endi = (kind == 0) ? B : (kind == 1) ? k + 1 + CL + RBL : k + M + TRP;
        last = (kind == 0) ? B - 1 : k;
        noise = run_no[0];
        dev_lo = -1; dev_hi = -2;
        run_no++;
        wr_col   = COL_W'(run_no * 37);
        wr_bank  = BANK_W'(run_no);
        int_col  = COL_W'(run_no * 11 + 3);
        int_bank = BANK_W'(run_no + 1);
        act_row  = ROW_W'(run_no * 13 + 5);
        bl_code  = 2'(bl);
        brsw     = bs[0];
        cas_lat  = 2'(cl);
        twr      = TWR_W'(m);
        int_kind = (kind == 1) ? 2'd0 : (kind == 2) ? 2'd1 : (run_no[0] ? 2'd3 : 2'd2);
        wr_req   = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        for (int i = 0; i <= endi; i++) begin
            oc = {cs_n, ras_n, cas_n, we_n};
            if (i == 0) ec = C_WR;
            else if (kind == 1 && i == k + 1) ec = C_RD;
            else if (kind >= 2 && i == k + M) ec = C_PRE;
            else if (kind >= 2 && i == k + M + TRP) ec = C_ACT;
            else ec = C_NOP;
            chk(cmd_tag(ec), int'(oc), int'(ec));
            chk(bs ? "R3 dq_oe" : (kind == 1 ? "R5 dq_oe" : "R2 dq_oe"),
                int'(dq_oe), (i <= last) ? 1 : 0);
            chk(bs ? "R3 wr_beat" : "R2 wr_beat", int'(wr_beat), (i <= last) ? i : 0);
            chk("R8 dqm", int'(dqm), (kind >= 2 && B > 2 && i > k && i <= k + M) ? 1 : 0);
            chk("R6 rd_valid", int'(rd_valid),
                (kind == 1 && i >= k + 1 + CL && i <= k + CL + RBL) ? 1 : 0);
            chk("R4 ready", int'(ready), (i >= endi) ? 1 : 0);
            if (oc == C_WR && ec == C_WR) begin
                chk("R2 addr", int'(addr), int'(wr_col));
                chk("R2 bank", int'(ba), int'(wr_bank));
            end
            if (oc == C_RD && ec == C_RD) begin
                chk("R5 addr", int'(addr), int'(int_col));
                chk("R5 bank", int'(ba), int'(int_bank));
            end
            if (oc == C_PRE && ec == C_PRE) begin
                chk("R7 bank", int'(ba), int'(int_bank));
                chk("R7 all-bank bit", int'(addr[10]), (kind == 3) ? 1 : 0);
            end
            if (oc == C_ACT && ec == C_ACT) begin
                chk("R9 row", int'(addr), int'(act_row));
                chk("R9 bank", int'(ba), int'(int_bank));
            end
            if (oc == C_RD) begin
                dev_lo = i + CL;
                dev_hi = i + CL + RBL - 1;
            end
            if (i >= dev_lo && i <= dev_hi) chk("R10 contention", int'(dq_oe), 0);
            wr_req  = noise && i >= 1 && i <= endi - 1;
            int_req = (kind != 0 && i == k) ||
                      (noise && kind != 0 && i > k && i <= endi - 1);
            @(negedge clk);
        end
        wr_req  = 1'b0;
        int_req = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; wr_req = 1'b0; int_req = 1'b0; int_kind = 2'd0;
        wr_col = '0; wr_bank = '0; int_col = '0; int_bank = '0; act_row = '0;
        bl_code = 2'd2; brsw = 1'b0; cas_lat = 2'd2; twr = 4'd2;
        repeat (3) @(negedge clk);
        chk("R1 command in reset", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 command", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 dqm", int'(dqm), 0);
        chk("R1 ready", int'(ready), 1);
        // R4: interrupt while idle has no effect
        int_req = 1'b1;
        int_kind = 2'd1;
        @(negedge clk);
        int_req = 1'b0;
        chk("R4 idle interrupt command", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        chk("R4 idle interrupt ready", int'(ready), 1);
        @(negedge clk);
        chk("R4 idle interrupt later", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        for (int bl = 0; bl < 4; bl++)
            for (int bs = 0; bs < 2; bs++)
                for (int cl = 1; cl < 4; cl++)
                    for (int m = 0; m < 4; m++)
                        for (int kind = 0; kind < 4; kind++) begin
                            int B;
                            B = bs ? 1 : (1 << bl);
                            for (int k = 0; k < ((kind == 0) ? 1 : B); k++)
                                run(bl, bs, cl, m, kind, k);
                        end
        // R6: latency code 0 treated as 1
        run(2, 0, 0, 1, 1, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule